// File: doc/BRIEF.md
# Multiprocessor Boot and Halt Controller

This block decides, after a system reset, which processor cores of a multi-core cluster may run, and from which address each one starts. Only core 0 can come out of reset on its own. Two board-level inputs choose its first state: a break request and a debug-enable strap. Every other core waits in power-down until software releases it.

Software releases cores through a small register port with write-enable, address and data. A release register lets halted cores run from the fixed default start address. A start-vector register holds a programmable start address. A boot register lets halted cores run from that programmable address. For each core the block outputs a two-bit run state and the start address that the core fetches from.

Top module: `mpboot_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), every core state reads power-down (code 00), every start address equals the default address, and the start vector equals the default address.
- R2: If the break input is low in the first cycle after reset is released, core 0 reaches run (code 11) with the default start address on the next clock.
- R3: If the break input is high and debug-enable is low in that first cycle, core 0 reaches halt (code 01).
- R4: If both break and debug-enable are high in that first cycle, core 0 reaches debug (code 10).
- R5: Break and debug-enable are sampled only in that first cycle. Later changes to them do not alter any core state.
- R6: Cores other than core 0 stay in power-down after reset until software releases them.
- R7: A write to the release register (address 0) with bit i set moves core i from halt or power-down to run on the next clock, with the default start address. This holds even after the start vector has been changed.
- R8: A write to the start-vector register (address 1) stores the full data word. A later write to the boot register (address 2) with bit i set moves halted or powered-down core i to run, with start address equal to the stored vector.
- R9: A combinational read at address 0 returns one bit per core, set while that core is in halt or power-down. Address 1 returns the start vector. Address 2 and address 3 return zero.
- R10: A release bit for a core that is in run or debug has no effect on its state or address. Zero bits never halt a core.
- R11: If a release or boot write sets bit 0 in the first cycle after reset, the strap decision for core 0 takes precedence and the write bit is ignored for core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brk_req | input | 1 | Break request, sampled in the first cycle after reset |
| dbg_strap | input | 1 | Debug-enable strap, sampled with the break request |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 release, 1 start vector, 2 boot |
| reg_wdata | input | AW | Register write data; bit i addresses core i |
| reg_rdata | output | AW | Combinational read data for reg_addr |
| core_state | output | 2*NCORES | Per-core state: 00 power-down, 01 halt, 10 debug, 11 run |
| core_start | output | AW*NCORES | Per-core start address |

## Verification
The strap decision for core 0 and a software release can fall in the same cycle: the first cycle after reset. The bench raises reset together with a release write that sets bit 0 while the break input is high. A reference model in the bench, which gives the strap priority, is compared on every clock, so core 0 is judged to settle in halt rather than run. The same write also releases other cores in that cycle, and their release is checked against the model.

// File: rtl/mpboot_pkg.sv
// Shared types for the multiprocessor boot and halt controller.
// Assumes a two-bit register address space.
package mpboot_pkg;

    typedef enum logic [1:0] {
        CS_PWRDN = 2'b00,
        CS_HALT  = 2'b01,
        CS_DEBUG = 2'b10,
        CS_RUN   = 2'b11
    } core_state_e;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] RA_RELEASE = 2'd0;
    localparam logic [REG_AW-1:0] RA_VECTOR  = 2'd1;
    localparam logic [REG_AW-1:0] RA_BOOT    = 2'd2;

endpackage

// File: rtl/mpboot_strap.sv
// Detects the first cycle after reset release and decodes the break and
// debug-enable straps into the initial state of core 0.
// Assumes the straps are already synchronous to clk.
module mpboot_strap
    import mpboot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        brk_req,
    input  logic        dbg_strap,
    output logic        boot_cycle,
    output core_state_e init_state
);

    logic seen_q;

    // Remember that the first post-reset cycle has passed
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // High only during the first cycle with reset released
    assign boot_cycle = rst_n && !seen_q;

    // Strap decode for core 0
    always_comb begin
        if (!brk_req)      init_state = CS_RUN;
        else if (dbg_strap) init_state = CS_DEBUG;
        else               init_state = CS_HALT;
    end

    // R5
    // boot_pulse_chk
    boot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_cycle |=> !boot_cycle);

endmodule

// File: rtl/mpboot_regs.sv
// Register decode: release, start-vector and boot registers plus readback.
// Assumes NCORES <= AW so that one data word covers every core bit.
module mpboot_regs
    import mpboot_pkg::*;
#(
    parameter int             NCORES     = 4,
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  RESET_ADDR = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [REG_AW-1:0] addr,
    input  logic [AW-1:0]     wdata,
    input  logic [NCORES-1:0] halted_mask,
    output logic [AW-1:0]     rdata,
    output logic [NCORES-1:0] rel_def,
    output logic [NCORES-1:0] rel_vec,
    output logic [AW-1:0]     vec
);

    logic [AW-1:0] vec_q;
    logic          vec_we;

    assign vec_we = wen && (addr == RA_VECTOR);

    // Start vector storage
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= RESET_ADDR;
        else if (vec_we) vec_q <= wdata;
    end

    // Release strobes toward the per-core state machines
    assign rel_def = (wen && addr == RA_RELEASE) ? wdata[NCORES-1:0] : '0;
    assign rel_vec = (wen && addr == RA_BOOT)    ? wdata[NCORES-1:0] : '0;
    assign vec     = vec_q;

    // Combinational readback
    always_comb begin
        case (addr)
            RA_RELEASE: rdata = AW'(halted_mask);
            RA_VECTOR:  rdata = vec_q;
            default:    rdata = '0;
        endcase
    end

    // R8
    // vec_hold_chk
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen && addr == RA_VECTOR) |=> $stable(vec_q));

    // R8
    // vec_load_chk
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && addr == RA_VECTOR) |=> (vec_q == $past(wdata)));

endmodule

// File: rtl/mpboot_core_fsm.sv
// Run-state machine for one core. The primary core takes its strap
// decision in the boot cycle. Any halted or powered-down core may be
// released to run from the default address or the programmed vector.
// Assumes rel_def and rel_vec are never set together.
module mpboot_core_fsm
    import mpboot_pkg::*;
#(
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  RESET_ADDR = 32'h0000_1000,
    parameter bit             IS_PRIMARY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boot_cycle,
    input  core_state_e init_state,
    input  logic        rel_def,
    input  logic        rel_vec,
    input  logic [AW-1:0] vec,
    output logic [1:0]  state_o,
    output logic [AW-1:0] addr_o,
    output logic        halted_o
);

    core_state_e   st_q;
    logic [AW-1:0] addr_q;
    logic          take_boot;
    logic          halted;

    assign take_boot = IS_PRIMARY && boot_cycle;
    assign halted    = (st_q == CS_PWRDN) || (st_q == CS_HALT);

    // State and start-address update; strap beats software release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_PWRDN;
            addr_q <= RESET_ADDR;
        end else if (take_boot) begin
            st_q   <= init_state;
            addr_q <= RESET_ADDR;
        end else if (halted && rel_vec) begin
            st_q   <= CS_RUN;
            addr_q <= vec;
        end else if (halted && rel_def) begin
            st_q   <= CS_RUN;
            addr_q <= RESET_ADDR;
        end
    end

    assign state_o  = st_q;
    assign addr_o   = addr_q;
    assign halted_o = halted;

    // R10
    // run_hold_chk
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_RUN) |=> (st_q == CS_RUN) && $stable(addr_q));

    // R10
    // debug_hold_chk
    debug_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_DEBUG) |=> (st_q == CS_DEBUG));

    // R7
    // def_release_chk
    def_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && rel_def && !take_boot) |=> (st_q == CS_RUN) && (addr_q == RESET_ADDR));

    // R6
    // idle_hold_chk
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !rel_def && !rel_vec && !take_boot) |=> $stable(st_q));

endmodule

// File: rtl/mpboot_ctrl.sv
// Top of the multiprocessor boot and halt controller. It joins the strap
// sampler, the register decode and one state machine per core.
// Assumes synchronous straps and a single-cycle register write port.
module mpboot_ctrl
    import mpboot_pkg::*;
#(
    parameter int             NCORES     = 4,
    parameter int             AW         = 32,
    parameter logic [AW-1:0]  RESET_ADDR = 32'h0000_1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   brk_req,
    input  logic                   dbg_strap,
    input  logic                   reg_wen,
    input  logic [1:0]             reg_addr,
    input  logic [AW-1:0]          reg_wdata,
    output logic [AW-1:0]          reg_rdata,
    output logic [2*NCORES-1:0]    core_state,
    output logic [AW*NCORES-1:0]   core_start
);

    localparam int SW = 2;

    logic              boot_cycle;
    core_state_e       init_state;
    logic [NCORES-1:0] halted_mask;
    logic [NCORES-1:0] rel_def;
    logic [NCORES-1:0] rel_vec;
    logic [AW-1:0]     vec;

    mpboot_strap u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_req    (brk_req),
        .dbg_strap  (dbg_strap),
        .boot_cycle (boot_cycle),
        .init_state (init_state)
    );

    mpboot_regs #(
        .NCORES     (NCORES),
        .AW         (AW),
        .RESET_ADDR (RESET_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wen         (reg_wen),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .halted_mask (halted_mask),
        .rdata       (reg_rdata),
        .rel_def     (rel_def),
        .rel_vec     (rel_vec),
        .vec         (vec)
    );

    // One state machine per core; only index 0 is the primary core
    for (genvar i = 0; i < NCORES; i++) begin : g_core
        mpboot_core_fsm #(
            .AW         (AW),
            .RESET_ADDR (RESET_ADDR),
            .IS_PRIMARY (i == 0)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .boot_cycle (boot_cycle),
            .init_state (init_state),
            .rel_def    (rel_def[i]),
            .rel_vec    (rel_vec[i]),
            .vec        (vec),
            .state_o    (core_state[SW*i +: SW]),
            .addr_o     (core_start[AW*i +: AW]),
            .halted_o   (halted_mask[i])
        );
    end

    // R6
    // secondary_wait_chk
    secondary_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cycle && rel_def == '0 && rel_vec == '0)
            |=> (core_state[2*NCORES-1:SW] == '0));

endmodule

// File: tb/mpboot_ctrl_bench.sv
// Bench for mpboot_ctrl: a behavioural reference model updated on every
// rising edge and compared 5 ns later on every clock.
module mpboot_ctrl_bench;

    localparam int          NC = 4;
    localparam int          AW = 32;
    localparam logic [31:0] RA = 32'h0000_1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              brk_req = 1'b0;
    logic              dbg_strap = 1'b0;
    logic              reg_wen = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [AW-1:0]     reg_wdata = '0;
    logic [AW-1:0]     reg_rdata;
    logic [2*NC-1:0]   core_state;
    logic [AW*NC-1:0]  core_start;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    int          m_st [NC];
    logic [31:0] m_ad [NC];
    logic [31:0] m_vec;
    bit          m_seen;

    mpboot_ctrl #(.NCORES(NC), .AW(AW), .RESET_ADDR(RA)) u_mpboot_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_req    (brk_req),
        .dbg_strap  (dbg_strap),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .core_state (core_state),
        .core_start (core_start)
    );

    always #10 clk = ~clk;

    // Reference model: states 0 pwrdn, 1 halt, 2 debug, 3 run
    always @(posedge clk) begin
        bit first;
        logic [31:0] old_vec;
        first   = !m_seen;
        old_vec = m_vec;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin m_st[i] = 0; m_ad[i] = RA; end
            m_vec  = RA;
            m_seen = 0;
        end else begin
            if (first) begin
                m_st[0] = !brk_req ? 3 : (dbg_strap ? 2 : 1);
                m_ad[0] = RA;
                m_seen  = 1;
            end
            if (reg_wen && reg_addr == 2'd1) m_vec = reg_wdata;
            if (reg_wen && (reg_addr == 2'd0 || reg_addr == 2'd2)) begin
                for (int i = 0; i < NC; i++) begin
                    if (reg_wdata[i] && m_st[i] <= 1 && !(i == 0 && first)) begin
                        m_st[i] = 3;
                        m_ad[i] = (reg_addr == 2'd2) ? old_vec : RA;
                    end
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = '0;
        if (reg_addr == 2'd0) begin
            for (int i = 0; i < NC; i++) r[i] = (m_st[i] <= 1);
        end else if (reg_addr == 2'd1) begin
            r = m_vec;
        end
        return r;
    endfunction

    // Compare against the model 5 ns after every rising edge
    always @(posedge clk) begin
        #5;
        for (int i = 0; i < NC; i++) begin
            checks++;
            if (core_state[2*i +: 2] != 2'(m_st[i]) || core_start[32*i +: 32] != m_ad[i]) begin
                errors++;
                $display("FAIL %s core%0d state/addr actual %0d/%h expected %0d/%h",
                         cur_req, i, core_state[2*i +: 2], core_start[32*i +: 32],
                         m_st[i], m_ad[i]);
            end
        end
        checks++;
        if (reg_rdata != exp_rdata()) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", cur_req, reg_rdata, exp_rdata());
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        reg_addr = a;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset(input logic b, input logic d);
        @(negedge clk);
        rst_n = 1'b0; brk_req = b; dbg_strap = d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state, R2 and R6 after release with break low
        cur_req = "R1";
        repeat (4) @(negedge clk);
        cur_req = "R2";
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cur_req = "R6";
        rd(2'd0);
        // R5 late strap changes are ignored
        cur_req = "R5";
        brk_req = 1'b1; dbg_strap = 1'b1;
        repeat (3) @(negedge clk);
        // R7 release core 1 from the default address
        cur_req = "R7";
        wr(2'd0, 32'h2);
        // R10 repeated and zero writes
        cur_req = "R10";
        wr(2'd0, 32'h3);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h0);
        // R9 readback of every address
        cur_req = "R9";
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);
        // R8 program vector and boot core 2
        cur_req = "R8";
        wr(2'd1, 32'h8000_0100);
        rd(2'd1);
        wr(2'd2, 32'h4);
        // R7 release core 3 after vector change uses default address
        cur_req = "R7";
        wr(2'd0, 32'h8);
        rd(2'd0);

        // R3 break high, debug low
        cur_req = "R3";
        do_reset(1'b1, 1'b0);
        rd(2'd0);
        cur_req = "R7";
        wr(2'd0, 32'h1);
        cur_req = "R8";
        wr(2'd1, 32'hCAFE_0000);
        wr(2'd2, 32'hE);
        rd(2'd0);

        // R4 break and debug high; R10 release ignored in debug
        cur_req = "R4";
        do_reset(1'b1, 1'b1);
        cur_req = "R10";
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd0);

        // R11 write in the first cycle after reset, strap says halt
        cur_req = "R11";
        @(negedge clk);
        rst_n = 1'b0; brk_req = 1'b1; dbg_strap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; reg_wen = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h3;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
        rd(2'd0);
        cur_req = "R2";
        do_reset(1'b0, 1'b1);
        rd(2'd0);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule